// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block resolves data hazards for a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. It keeps its own copy of the pipeline-register fields it needs: source numbers and use flags in the decode/execute register, and destination, write enable and load flag in the later registers. For each of the three source operands of the instruction in execute, it drives a select. The select picks one of three values: the register-file value, the result held in the execute/memory register, or the result held in the memory/writeback register.

When the instruction in decode reads the destination of a load that is currently in execute, the unit raises a stall and a bubble together for exactly one cycle. The surrounding pipeline holds its PC and its fetch/decode register during that cycle. The unit itself loads a no-op with write enable cleared into its decode/execute register. A small state machine has two states, `S_FLOW` and `S_HOLD`. The transition `FLOW_TO_HOLD` fires when a load-use hazard is seen in `S_FLOW`. The transition `HOLD_TO_FLOW` always follows one cycle later. `S_FLOW` stays in `S_FLOW` when there is no hazard (`FLOW_STAY`).

Top module: `hz_fwd_interlock`

## Requirements
- R1: An operand whose source number equals the destination in the execute/memory register, with that register's write enable set, gets select code 1 (2'b01).
- R2: An operand that matches only the destination in the memory/writeback register, with its write enable set, gets select code 2 (2'b10).
- R3: When both later registers match an operand, code 1 (the younger result) wins over code 2.
- R4: A destination whose write enable is clear never causes forwarding or a stall. An operand whose use flag is clear gets code 0 (2'b00, register file).
- R5: A used source of the valid decode instruction that equals the destination of a writing load in execute raises stall and bubble for exactly one cycle. The execute stage then holds a no-op.
- R6: After a load-use stall, the consuming instruction reaches execute with the load in the memory/writeback register and selects it with code 2.
- R7: A load whose result is first used two or more instructions later causes no stall.
- R8: A sequence of dependent ALU instructions issues one instruction per cycle with no stall. A run of N instructions with one load-use pair takes N+1 issue cycles.
- R9: After reset all tracked registers are empty: stall and bubble are 0 and every select is code 0.
- R10: The three operand selects are decided independently, so one instruction may carry codes 1, 2 and 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_src | input | NSRC*RW | Source register numbers of the decode instruction, operand i at bits [i*RW +: RW] |
| id_used | input | NSRC | Per-operand use flag of the decode instruction |
| id_dst | input | RW | Destination register of the decode instruction |
| id_wen | input | 1 | Decode instruction writes its destination |
| id_load | input | 1 | Decode instruction is a load |
| stall | output | 1 | Hold PC and fetch/decode register this cycle |
| bubble | output | 1 | A no-op enters execute at the next edge |
| ex_fwd_sel | output | NSRC*2 | Operand selects for execute, operand i at bits [i*2 +: 2]: 0 register file, 1 execute/memory, 2 memory/writeback |

## Verification
The hardest state to reach is a consumer in execute with the load in the memory/writeback register and a bubble in the execute/memory register. Only a real load-use stall produces this state. The bench reaches it by driving a load followed at once by its consumer, and it advances its decode slot only when the unit's own stall is low, so the held instruction is presented again. Programs that put two writers of one register back to back, and that mix write-disabled producers with unused operands, cover the priority and qualification corners.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_MEM = 2'd1,
        FWD_WB  = 2'd2
    } fwd_sel_e;

    typedef enum logic {
        S_FLOW = 1'b0,
        S_HOLD = 1'b1
    } lock_state_e;
endpackage

// File: rtl/hz_stage_track.sv
module hz_stage_track #(
    parameter int RW   = 4,
    parameter int NSRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bubble,
    input  logic               id_valid,
    input  logic [NSRC*RW-1:0] id_src,
    input  logic [NSRC-1:0]    id_used,
    input  logic [RW-1:0]      id_dst,
    input  logic               id_wen,
    input  logic               id_load,
    output logic [NSRC*RW-1:0] ex_src,
    output logic [NSRC-1:0]    ex_used,
    output logic [RW-1:0]      ex_dst,
    output logic               ex_wen,
    output logic               ex_load,
    output logic [RW-1:0]      mem_dst,
    output logic               mem_wen,
    output logic [RW-1:0]      wb_dst,
    output logic               wb_wen
);
    logic take;
    assign take = id_valid && !bubble;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_src  <= '0;
            ex_used <= '0;
            ex_dst  <= '0;
            ex_wen  <= 1'b0;
            ex_load <= 1'b0;
            mem_dst <= '0;
            mem_wen <= 1'b0;
            wb_dst  <= '0;
            wb_wen  <= 1'b0;
        end else begin
            ex_src  <= take ? id_src  : '0;
            ex_used <= take ? id_used : '0;
            ex_dst  <= take ? id_dst  : '0;
            ex_wen  <= take && id_wen;
            ex_load <= take && id_load;
            mem_dst <= ex_dst;
            mem_wen <= ex_wen;
            wb_dst  <= mem_dst;
            wb_wen  <= mem_wen;
        end
    end

    // R5: a bubble leaves a no-op in the execute register
    a_r5_bubble_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (!ex_wen && !ex_load && ex_used == '0));
endmodule

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
    import hz_pkg::*;
#(
    parameter int RW = 4
) (
    input  logic [RW-1:0] src,
    input  logic          used,
    input  logic [RW-1:0] mem_dst,
    input  logic          mem_wen,
    input  logic [RW-1:0] wb_dst,
    input  logic          wb_wen,
    output fwd_sel_e      sel
);
    logic hit_mem, hit_wb;
    assign hit_mem = used && mem_wen && (mem_dst == src);
    assign hit_wb  = used && wb_wen  && (wb_dst  == src);

    always_comb begin
        if (hit_mem)     sel = FWD_MEM;
        else if (hit_wb) sel = FWD_WB;
        else             sel = FWD_RF;
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int RW   = 4,
    parameter int NSRC = 3
) (
    input  logic               id_valid,
    input  logic [NSRC*RW-1:0] id_src,
    input  logic [NSRC-1:0]    id_used,
    input  logic [RW-1:0]      ex_dst,
    input  logic               ex_wen,
    input  logic               ex_load,
    output logic               hazard
);
    logic [NSRC-1:0] hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_cmp
        assign hit[i] = id_used[i] && (id_src[i*RW +: RW] == ex_dst);
    end

    assign hazard = id_valid && ex_wen && ex_load && (|hit);
endmodule

// File: rtl/hz_fwd_interlock.sv
module hz_fwd_interlock
    import hz_pkg::*;
#(
    parameter int RW   = 4,
    parameter int NSRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               id_valid,
    input  logic [NSRC*RW-1:0] id_src,
    input  logic [NSRC-1:0]    id_used,
    input  logic [RW-1:0]      id_dst,
    input  logic               id_wen,
    input  logic               id_load,
    output logic               stall,
    output logic               bubble,
    output logic [NSRC*2-1:0]  ex_fwd_sel
);
    localparam int SELW = 2;

    logic [NSRC*RW-1:0] ex_src;
    logic [NSRC-1:0]    ex_used;
    logic [RW-1:0]      ex_dst, mem_dst, wb_dst;
    logic               ex_wen, ex_load, mem_wen, wb_wen;
    logic               hazard;
    lock_state_e        state_q, state_d;
    logic [NSRC-1:0]    sel_wb;

    hz_stage_track #(.RW(RW), .NSRC(NSRC)) u_track (
        .clk(clk), .rst_n(rst_n), .bubble(bubble),
        .id_valid(id_valid), .id_src(id_src), .id_used(id_used),
        .id_dst(id_dst), .id_wen(id_wen), .id_load(id_load),
        .ex_src(ex_src), .ex_used(ex_used), .ex_dst(ex_dst),
        .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wen(mem_wen),
        .wb_dst(wb_dst), .wb_wen(wb_wen)
    );

    hz_load_use #(.RW(RW), .NSRC(NSRC)) u_lu (
        .id_valid(id_valid), .id_src(id_src), .id_used(id_used),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
        .hazard(hazard)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_op
        fwd_sel_e sel_i;
        hz_operand_sel #(.RW(RW)) u_sel (
            .src(ex_src[i*RW +: RW]), .used(ex_used[i]),
            .mem_dst(mem_dst), .mem_wen(mem_wen),
            .wb_dst(wb_dst), .wb_wen(wb_wen),
            .sel(sel_i)
        );
        assign ex_fwd_sel[i*SELW +: SELW] = sel_i;
        assign sel_wb[i] = (sel_i == FWD_WB);

        // R4: an unused operand reads the register file
        a_r4_unused_rf: assert property (@(posedge clk) disable iff (!rst_n)
            !ex_used[i] |-> (sel_i == FWD_RF));
        // R3: a younger writer of the same register wins
        a_r3_younger_first: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_used[i] && mem_wen && wb_wen && mem_dst == wb_dst
             && ex_src[i*RW +: RW] == mem_dst) |-> (sel_i == FWD_MEM));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_FLOW;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        stall   = 1'b0;
        unique case (state_q)
            S_FLOW: begin
                if (hazard) begin          // FLOW_TO_HOLD
                    state_d = S_HOLD;
                    stall   = 1'b1;
                end                        // else FLOW_STAY
            end
            S_HOLD: begin
                state_d = S_FLOW;          // HOLD_TO_FLOW
            end
            default: state_d = S_FLOW;
        endcase
        bubble = stall;
    end

    // R5: exactly one stall cycle per load-use pair
    a_r5_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    // R6: two cycles after a stall the load result comes from memory/writeback
    a_r6_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ##1 (|sel_wb));
endmodule

// File: tb/tb_hz_fwd_interlock.sv
module tb_hz_fwd_interlock;
    localparam int RW = 4;
    localparam int NSRC = 3;

    typedef struct packed {
        logic          v;
        logic [3:0]    s2, s1, s0;
        logic [2:0]    u;
        logic [3:0]    d;
        logic          w;
        logic          ld;
    } ins_t;

    typedef struct packed {
        logic       st;
        logic [5:0] sel;
        int         tag;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic id_valid, id_wen, id_load, stall, bubble;
    logic [NSRC*RW-1:0] id_src;
    logic [NSRC-1:0] id_used;
    logic [RW-1:0] id_dst;
    logic [NSRC*2-1:0] ex_fwd_sel;

    int n_chk = 0, n_fail = 0;
    exp_t expq[$];
    ins_t exs[3];
    ins_t prog[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    hz_fwd_interlock #(.RW(RW), .NSRC(NSRC)) dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_src(id_src),
        .id_used(id_used), .id_dst(id_dst), .id_wen(id_wen),
        .id_load(id_load), .stall(stall), .bubble(bubble),
        .ex_fwd_sel(ex_fwd_sel)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic ins_t mk(logic w, logic ld, logic [3:0] d, logic [2:0] u,
                                logic [3:0] a, logic [3:0] b, logic [3:0] c);
        ins_t t;
        t.v = 1; t.w = w; t.ld = ld; t.d = d; t.u = u;
        t.s0 = a; t.s1 = b; t.s2 = c;
        return t;
    endfunction

    function automatic logic [1:0] msel(logic u, logic [3:0] s);
        if (!u) return 2'd0;
        if (exs[1].w && exs[1].d == s) return 2'd1;
        if (exs[2].w && exs[2].d == s) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic mstall(ins_t t);
        logic m;
        m = (t.u[0] && t.s0 == exs[0].d) || (t.u[1] && t.s1 == exs[0].d)
            || (t.u[2] && t.s2 == exs[0].d);
        return t.v && exs[0].w && exs[0].ld && m;
    endfunction

    task automatic apply(ins_t t);
        id_valid = t.v; id_src = {t.s2, t.s1, t.s0}; id_used = t.u;
        id_dst = t.d; id_wen = t.w; id_load = t.ld;
    endtask

    // one cycle: drive, push expectation, advance model
    task automatic step(ins_t t, int tag, output logic dut_st);
        exp_t e;
        logic ms;
        @(posedge clk); #1;
        apply(t);
        ms = mstall(t);
        e.st = ms;
        e.sel = {msel(exs[0].u[2], exs[0].s2), msel(exs[0].u[1], exs[0].s1),
                 msel(exs[0].u[0], exs[0].s0)};
        e.tag = tag;
        expq.push_back(e);
        @(negedge clk);
        dut_st = stall;
        exs[2] = exs[1];
        exs[1] = exs[0];
        exs[0] = ms ? ins_t'(0) : (t.v ? t : ins_t'(0));
    endtask

    task automatic run(int tag, int exp_cycles);
        int pc = 0, cyc = 0;
        logic st;
        while (pc < prog.size()) begin
            step(prog[pc], tag, st);
            if (!st) pc++;
            cyc++;
        end
        for (int k = 0; k < 3; k++) step(ins_t'(0), tag, st);
        // R8: issue cycle count
        chk($sformatf("R8 cycles prog%0d", tag), cyc, exp_cycles);
        prog.delete();
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            chk($sformatf("R5 stall prog%0d", e.tag), stall, e.st);
            chk($sformatf("R5 bubble prog%0d", e.tag), bubble, e.st);
            chk($sformatf("R1 R2 R3 R4 R6 R10 sel prog%0d", e.tag), ex_fwd_sel, e.sel);
        end
    end

    initial begin
        apply(ins_t'(0));
        exs[0] = '0; exs[1] = '0; exs[2] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R9 stall", stall, 0);
        chk("R9 bubble", bubble, 0);
        chk("R9 sel", ex_fwd_sel, 0);

        // P1: ALU chain, R1 then R2, no stall (R8)
        prog.push_back(mk(1,0,4'd1,3'b011,4'd2,4'd3,4'd0));
        prog.push_back(mk(1,0,4'd4,3'b011,4'd5,4'd1,4'd0));
        prog.push_back(mk(1,0,4'd6,3'b011,4'd1,4'd7,4'd0));
        prog.push_back(mk(1,0,4'd8,3'b011,4'd1,4'd9,4'd0));
        prog.push_back(mk(1,0,4'd10,3'b011,4'd1,4'd11,4'd0));
        run(1, 5);
        // P2: load-use, six instructions in seven cycles (R5, R6)
        prog.push_back(mk(1,1,4'd1,3'b001,4'd2,4'd0,4'd0));
        prog.push_back(mk(1,0,4'd4,3'b011,4'd1,4'd5,4'd0));
        prog.push_back(mk(1,0,4'd6,3'b011,4'd1,4'd7,4'd0));
        prog.push_back(mk(1,0,4'd8,3'b011,4'd1,4'd9,4'd0));
        prog.push_back(mk(1,0,4'd12,3'b001,4'd4,4'd0,4'd0));
        prog.push_back(mk(1,0,4'd13,3'b001,4'd6,4'd0,4'd0));
        run(2, 7);
        // P3: load consumed later, no stall (R7)
        prog.push_back(mk(1,1,4'd1,3'b001,4'd2,4'd0,4'd0));
        prog.push_back(mk(1,0,4'd3,3'b011,4'd2,4'd2,4'd0));
        prog.push_back(mk(1,0,4'd4,3'b001,4'd1,4'd0,4'd0));
        prog.push_back(mk(1,0,4'd5,3'b001,4'd3,4'd0,4'd0));
        prog.push_back(mk(1,0,4'd6,3'b011,4'd4,4'd5,4'd0));
        prog.push_back(mk(1,0,4'd7,3'b001,4'd6,4'd0,4'd0));
        run(3, 6);
        // P4: two writers of r5, consumer with all three operands r5 (R3, R10)
        prog.push_back(mk(1,0,4'd5,3'b001,4'd1,4'd0,4'd0));
        prog.push_back(mk(1,0,4'd5,3'b001,4'd2,4'd0,4'd0));
        prog.push_back(mk(1,0,4'd6,3'b111,4'd5,4'd5,4'd5));
        run(4, 3);
        // P5: write-disabled producers and unused operands (R4)
        prog.push_back(mk(0,0,4'd7,3'b001,4'd1,4'd0,4'd0));
        prog.push_back(mk(1,0,4'd8,3'b101,4'd7,4'd7,4'd7));
        prog.push_back(mk(0,1,4'd9,3'b001,4'd1,4'd0,4'd0));
        prog.push_back(mk(1,0,4'd10,3'b001,4'd9,4'd0,4'd0));
        prog.push_back(mk(1,0,4'd11,3'b100,4'd10,4'd10,4'd8));
        run(5, 5);
        // P6: mixed codes 1, 2, 0 in one instruction (R10)
        prog.push_back(mk(1,0,4'd1,3'b001,4'd0,4'd0,4'd0));
        prog.push_back(mk(1,0,4'd2,3'b001,4'd0,4'd0,4'd0));
        prog.push_back(mk(1,0,4'd3,3'b111,4'd2,4'd1,4'd9));
        run(6, 3);
        // P7: load feeding third operand only, stall then code 2 (R5, R6)
        prog.push_back(mk(1,1,4'd14,3'b001,4'd0,4'd0,4'd0));
        prog.push_back(mk(1,0,4'd15,3'b110,4'd3,4'd3,4'd14));
        run(7, 3);

        done = 1;
    end

    initial begin
        int cnt = 0;
        while (!done && cnt < 20000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected done", cnt);
        end
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule